// File: doc/BRIEF.md
# MII management auto-poll sequencer

This block owns the two-wire MII management port (MDC clock, bidirectional MDIO data) of a network port. Whenever a hard or a soft reset ends, it can bring an external PHY into a known state. It does this with a short sequence of write frames to the PHY's control register. The sequence can start with a PHY reset. It then either turns auto-negotiation on or forces link speed and duplex.

When setup is done, and when auto-poll is enabled, the block reads one PHY register over and over. The time it waits between these reads comes from a 3-bit dwell code, counted in MDC periods. It keeps the last value it read. When a newly read value differs from the value it holds, it raises a one-cycle flag.

The control bits are plain inputs that a host register block holds. The PHY address and the polled register number are inputs too. The hard reset is asynchronous and active low. The soft reset is a synchronous one-cycle pulse.

Top module: `mii_autopoll_seq`

The controller has six states:
- `ST_ARM` picks the first setup step.
- `ST_RST_WR` sends the PHY-reset write.
- `ST_CFG_WR` sends the configuration write.
- `ST_IDLE` waits for auto-poll to be enabled.
- `ST_POLL_RD` runs one poll read.
- `ST_GAP` counts the dwell.

Its transitions are:
- ARM→RST_WR when a PHY reset is requested.
- ARM→CFG_WR when it is not.
- ARM→IDLE when auto setup is disabled.
- RST_WR→CFG_WR, CFG_WR→IDLE and POLL_RD→GAP, each when its frame completes.
- IDLE→POLL_RD when auto-poll is enabled.
- GAP→IDLE when the dwell has expired.
- Any state →ARM on a soft reset.

## Requirements
- R1: Every frame is sent MSB first, as 64 bit times, with bit-time index 0 first:
  - indices 0..31: preamble of 32 ones;
  - 32..33: start pattern 01;
  - 34..35: opcode (01 = write, 10 = read);
  - 36..40: 5-bit PHY address;
  - 41..45: 5-bit register number;
  - 46..47: turnaround, driven as 10 on a write;
  - 48..63: 16 data bits.

  MDIO out and its enable change only on a falling MDC edge.
- R2: In a poll read, the register number is `poll_reg` and the MDIO enable is low for indices 46..63. The data bits are sampled from `mdio_in` on the rising MDC edges and form `poll_data`, MSB first.
- R3: When auto setup is allowed and `phy_reset_req` is 1, the first frame after a reset writes 0x8000 to PHY register 0. The configuration write to register 0 follows it.
- R4: The configuration frame writes 0x1000 when `phy_aneg_en` is 1. Otherwise it writes a word that has bit 13 = `phy_100`, bit 8 = `phy_fdx` and all other bits 0.
- R5: When `no_auto_setup` is 1, no setup frame is sent after a reset, and no frame at all is sent while `poll_en` is 0.
- R6: After a read completes, the MDC idle periods before the next read number N+1. N is taken from `dwell_code`: 0→0, 1→128, 2→256, 3→512, 4→1024, 5→2048, and the reserved codes 6 and 7→2048. After a setup write there is 1 idle period.
- R7: When a read completes, `poll_data` takes the new value. `poll_change` pulses for exactly one cycle only if the new value differs from the value held before. `poll_data` never changes without that pulse.
- R8: A soft reset aborts any frame in progress by releasing MDIO. It then restarts the setup sequence using the current control bits, and it keeps `poll_data`.
- R9: MDC is a divided clock with period 2·MDC_HALF system clocks.
- R10: During hard reset, MDC and the MDIO enable are low, and `poll_data` and `poll_change` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | hard reset, asynchronous, active low |
| soft_rst | input | 1 | soft reset pulse, one cycle |
| poll_en | input | 1 | auto-poll enable |
| dwell_code | input | 3 | dwell between poll reads |
| no_auto_setup | input | 1 | suppress the setup sequence |
| phy_reset_req | input | 1 | send a PHY reset write first |
| phy_aneg_en | input | 1 | setup enables auto-negotiation |
| phy_fdx | input | 1 | forced full duplex |
| phy_100 | input | 1 | forced 100 Mbps |
| phy_addr | input | 5 | PHY address |
| poll_reg | input | 5 | polled register number |
| mdio_in | input | 1 | MDIO input from the pad |
| mdc | output | 1 | management clock |
| mdio_out | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |
| poll_data | output | 16 | last polled value |
| poll_change | output | 1 | one-cycle pulse when polled value changed |

## Verification
The assertions assume the following:
- `soft_rst` is a single-cycle pulse.
- The control inputs do not change while a frame is being sent.
- MDC_HALF is at least 2, so that a start issued after a frame completes is taken before the next falling MDC edge.

The stimulus respects these assumptions. It changes the control bits only in the same cycle as a reset pulse, or while the block is idle. It drives `mdio_in` from a PHY model that follows the frame position it decodes at each rising MDC edge. Soft resets are issued only after the previous read's result has settled, apart from one reset that is deliberately placed inside a frame.

// File: rtl/mii_ap_pkg.sv
package mii_ap_pkg;
    typedef enum logic [2:0] {
        ST_ARM, ST_RST_WR, ST_CFG_WR, ST_IDLE, ST_POLL_RD, ST_GAP
    } ap_state_t;

    localparam int FRAME_BITS = 64;
    localparam int TA_POS     = 46;
    localparam int DATA_POS   = 48;
    localparam logic [15:0] PHY_RESET_WORD = 16'h8000;
    localparam logic [15:0] ANEG_ON_WORD   = 16'h1000;

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic rd, input logic [4:0] phy, input logic [4:0] regad,
        input logic [15:0] data);
        return {32'hFFFF_FFFF, 2'b01, (rd ? 2'b10 : 2'b01), phy, regad,
                (rd ? 2'b11 : 2'b10), data};
    endfunction
endpackage

// File: rtl/mii_ap_mdc_gen.sv
module mii_ap_mdc_gen #(
    parameter int HALF = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic mdc,
    output logic fall_tick,
    output logic rise_tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == CW'(HALF - 1));
    assign fall_tick = wrap & mdc;
    assign rise_tick = wrap & ~mdc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/mii_ap_frame_eng.sv
module mii_ap_frame_eng
    import mii_ap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        fall_tick,
    input  logic        rise_tick,
    input  logic        start,
    input  logic        rd,
    input  logic [4:0]  phy,
    input  logic [4:0]  regad,
    input  logic [15:0] wdata,
    input  logic        mdio_in,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata
);
    localparam int CW = $clog2(FRAME_BITS) + 1;

    logic [FRAME_BITS-1:0] sreg;
    logic [CW-1:0]         cnt;
    logic                  rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg     <= '0;
            cnt      <= '0;
            rd_q     <= 1'b0;
            busy     <= 1'b0;
            done     <= 1'b0;
            mdio_out <= 1'b1;
            mdio_oe  <= 1'b0;
            rdata    <= '0;
        end else begin
            done <= 1'b0;
            if (clr) begin
                busy    <= 1'b0;
                mdio_oe <= 1'b0;
                cnt     <= '0;
            end else if (!busy) begin
                if (start) begin
                    sreg <= build_frame(rd, phy, regad, wdata);
                    rd_q <= rd;
                    cnt  <= '0;
                    busy <= 1'b1;
                end
            end else begin
                if (fall_tick) begin
                    if (cnt == CW'(FRAME_BITS)) begin
                        busy    <= 1'b0;
                        done    <= 1'b1;
                        mdio_oe <= 1'b0;
                    end else begin
                        mdio_out <= sreg[FRAME_BITS-1];
                        sreg     <= {sreg[FRAME_BITS-2:0], 1'b0};
                        mdio_oe  <= !(rd_q && cnt >= CW'(TA_POS));
                        cnt      <= cnt + 1'b1;
                    end
                end
                if (rise_tick && rd_q && cnt > CW'(DATA_POS))
                    rdata <= {rdata[14:0], mdio_in};
            end
        end
    end
endmodule

// File: rtl/mii_ap_dwell.sv
module mii_ap_dwell #(
    parameter int BASE = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [2:0] code,
    input  logic       fall_tick,
    output logic       expired
);
    localparam int DW = $clog2(BASE) + 6;

    logic [DW-1:0] cnt;

    function automatic logic [DW-1:0] span(input logic [2:0] c);
        if (c == 3'd0)      return '0;
        else if (c > 3'd5)  return DW'(BASE) << 5;
        else                return DW'(BASE) << c;
    endfunction

    assign expired = (cnt == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt <= '0;
        else if (load)               cnt <= span(code);
        else if (fall_tick && !expired) cnt <= cnt - 1'b1;
    end
endmodule

// File: rtl/mii_autopoll_seq.sv
module mii_autopoll_seq
    import mii_ap_pkg::*;
#(
    parameter int MDC_HALF   = 3,
    parameter int DWELL_BASE = 64
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        soft_rst,
    input  logic        poll_en,
    input  logic [2:0]  dwell_code,
    input  logic        no_auto_setup,
    input  logic        phy_reset_req,
    input  logic        phy_aneg_en,
    input  logic        phy_fdx,
    input  logic        phy_100,
    input  logic [4:0]  phy_addr,
    input  logic [4:0]  poll_reg,
    input  logic        mdio_in,
    output logic        mdc,
    output logic        mdio_out,
    output logic        mdio_oe,
    output logic [15:0] poll_data,
    output logic        poll_change
);
    ap_state_t   state_q, state_d;
    logic        fall_tick, rise_tick;
    logic        eng_start, eng_rd, eng_busy, eng_done;
    logic [4:0]  eng_reg;
    logic [15:0] eng_wdata, eng_rdata, cfg_word;
    logic        dwell_load, dwell_expired;

    mii_ap_mdc_gen #(.HALF(MDC_HALF)) u_mdc (
        .clk(clk), .rst_n(rst_n), .mdc(mdc),
        .fall_tick(fall_tick), .rise_tick(rise_tick)
    );

    mii_ap_frame_eng u_eng (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst),
        .fall_tick(fall_tick), .rise_tick(rise_tick),
        .start(eng_start), .rd(eng_rd), .phy(phy_addr), .regad(eng_reg),
        .wdata(eng_wdata), .mdio_in(mdio_in), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .busy(eng_busy), .done(eng_done), .rdata(eng_rdata)
    );

    mii_ap_dwell #(.BASE(DWELL_BASE)) u_dwell (
        .clk(clk), .rst_n(rst_n), .load(dwell_load), .code(dwell_code),
        .fall_tick(fall_tick), .expired(dwell_expired)
    );

    assign cfg_word = phy_aneg_en ? ANEG_ON_WORD
                                  : {2'b00, phy_100, 4'b0000, phy_fdx, 8'h00};

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ARM:     state_d = no_auto_setup ? ST_IDLE
                                : (phy_reset_req ? ST_RST_WR : ST_CFG_WR);
            ST_RST_WR:  if (eng_done) state_d = ST_CFG_WR;
            ST_CFG_WR:  if (eng_done) state_d = ST_IDLE;
            ST_IDLE:    if (poll_en) state_d = ST_POLL_RD;
            ST_POLL_RD: if (eng_done) state_d = ST_GAP;
            ST_GAP:     if (dwell_expired) state_d = ST_IDLE;
            default:    state_d = ST_ARM;
        endcase
    end

    // outputs towards frame engine and dwell timer
    always_comb begin
        eng_start  = 1'b0;
        eng_rd     = 1'b0;
        eng_reg    = 5'd0;
        eng_wdata  = cfg_word;
        dwell_load = 1'b0;
        unique case (state_q)
            ST_ARM: begin
                eng_start = !no_auto_setup && !eng_busy;
                eng_wdata = phy_reset_req ? PHY_RESET_WORD : cfg_word;
            end
            ST_RST_WR:  eng_start = eng_done;
            ST_CFG_WR:  eng_start = 1'b0;
            ST_IDLE: begin
                eng_start = poll_en && !eng_busy;
                eng_rd    = 1'b1;
                eng_reg   = poll_reg;
            end
            ST_POLL_RD: dwell_load = eng_done;
            ST_GAP:     dwell_load = 1'b0;
            default:    eng_start = 1'b0;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state_q <= ST_ARM;
        else if (soft_rst) state_q <= ST_ARM;
        else               state_q <= state_d;
    end

    // polled result and change flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            poll_data   <= '0;
            poll_change <= 1'b0;
        end else begin
            poll_change <= 1'b0;
            if (state_q == ST_POLL_RD && eng_done && !soft_rst) begin
                poll_data   <= eng_rdata;
                poll_change <= (eng_rdata != poll_data);
            end
        end
    end
endmodule

// File: rtl/mii_autopoll_seq_chk.sv
module mii_autopoll_seq_chk #(
    parameter int HALF = 3
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_out,
    input logic        mdio_oe,
    input logic [15:0] poll_data,
    input logic        poll_change
);
    localparam int HW = $clog2(HALF + 1) + 1;

    logic          mdc_q;
    logic [HW-1:0] held;

    // R9: every MDC level lasts HALF system clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mdc_q <= 1'b0;
            held  <= '0;
        end else begin
            mdc_q <= mdc;
            if (mdc != mdc_q) begin
                a_r9_mdc_half_period: assert (held == HW'(HALF))
                    else $error("MDC level lasted %0d clocks", held);
                held <= HW'(1);
            end else begin
                held <= held + 1'b1;
            end
        end
    end

    a_r1_mdio_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mdio_out) |-> $fell(mdc));

    a_r1_oe_rises_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> $fell(mdc));

    a_r7_change_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        poll_change |=> !poll_change);

    a_r7_data_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(poll_data) |-> poll_change);
endmodule

bind mii_autopoll_seq mii_autopoll_seq_chk #(.HALF(MDC_HALF)) u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_out(mdio_out),
    .mdio_oe(mdio_oe), .poll_data(poll_data), .poll_change(poll_change)
);

// File: tb/mii_autopoll_seq_test.sv
module mii_autopoll_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 3;

    logic clk = 1'b0;
    logic rst_n, soft_rst, poll_en, no_auto, rst_req, aneg, fdx, spd, mdio_in;
    logic [2:0]  dwell;
    logic [4:0]  phy_addr = 5'h0A;
    logic [4:0]  poll_reg = 5'h01;
    logic        mdc, mdio_out, mdio_oe, poll_change;
    logic [15:0] poll_data;

    int compared = 0, mismatched = 0, cyc = 0;

    // behavioural PHY / monitor state
    logic [15:0] wq[$];
    bit          in_frame, gap_valid, cur_rd, pend, mdc_prev;
    int          idx, idle_cnt, expect_gap, frames_seen, reads_done;
    int          exp_changes, seen_changes;
    logic [63:0] cur_w;
    logic [15:0] cur_data, prev_poll;

    mii_autopoll_seq #(.MDC_HALF(HALF), .DWELL_BASE(64)) uut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .poll_en(poll_en),
        .dwell_code(dwell), .no_auto_setup(no_auto), .phy_reset_req(rst_req),
        .phy_aneg_en(aneg), .phy_fdx(fdx), .phy_100(spd), .phy_addr(phy_addr),
        .poll_reg(poll_reg), .mdio_in(mdio_in), .mdc(mdc), .mdio_out(mdio_out),
        .mdio_oe(mdio_oe), .poll_data(poll_data), .poll_change(poll_change)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int dwell_len(input logic [2:0] c);
        case (c)
            3'd0: return 0;
            3'd1: return 128;
            3'd2: return 256;
            3'd3: return 512;
            3'd4: return 1024;
            default: return 2048;
        endcase
    endfunction

    function automatic logic [15:0] phy_val(input int n);
        return 16'h0F0F + 16'((n >> 1) * 16'h1111);
    endfunction

    task automatic arm_model();
        in_frame = 0; gap_valid = 0; pend = 0; idle_cnt = 0; mdio_in = 1'b1;
        wq.delete();
    endtask

    task automatic check_bit();
        string tag;
        if (cur_rd && idx >= 46) begin
            chk(mdio_oe == 1'b0, "R2 released", mdio_oe, 0);
        end else begin
            if (idx >= 48 && !cur_rd) tag = (cur_data == 16'h8000) ? "R3 data" : "R4 data";
            else tag = cur_rd ? "R2 header" : "R1 bit";
            chk(mdio_oe && mdio_out == cur_w[63-idx], tag,
                {mdio_oe, mdio_out}, {1'b1, cur_w[63-idx]});
        end
        if (cur_rd && idx >= 47 && idx < 63) mdio_in = cur_data[62-idx];
        if (idx == 63) mdio_in = 1'b1;
        idx++;
        if (idx == 64) begin
            in_frame = 0; idle_cnt = 0; gap_valid = 1;
            expect_gap = cur_rd ? dwell_len(dwell) + 1 : 1;
            if (cur_rd) begin
                reads_done++;
                if (cur_data != prev_poll) exp_changes++;
                prev_poll = cur_data;
                pend = 1;
            end
        end
    endtask

    task automatic on_rise();
        if (pend) begin
            pend = 0;
            chk(poll_data == cur_data, "R7 poll_data", poll_data, cur_data);
            chk(seen_changes == exp_changes, "R7 change pulses", seen_changes, exp_changes);
        end
        if (!in_frame) begin
            if (mdio_oe) begin
                in_frame = 1; idx = 0; frames_seen++;
                if (gap_valid) chk(idle_cnt == expect_gap, "R6 gap", idle_cnt, expect_gap);
                if (wq.size() > 0) begin
                    cur_rd = 0; cur_data = wq.pop_front();
                    cur_w = {32'hFFFF_FFFF, 2'b01, 2'b01, phy_addr, 5'd0, 2'b10, cur_data};
                end else begin
                    cur_rd = 1; cur_data = phy_val(reads_done);
                    cur_w = {32'hFFFF_FFFF, 2'b01, 2'b10, phy_addr, poll_reg, 2'b11, cur_data};
                end
                check_bit();
            end else begin
                idle_cnt++;
            end
        end else begin
            check_bit();
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && poll_change) seen_changes++;
        if (rst_n && !soft_rst && mdc && !mdc_prev) on_rise();
        mdc_prev = mdc;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            compared++; mismatched++;
            $display("FAIL watchdog expired actual=%0d expected=<150000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic wait_reads(input int n);
        while (!(reads_done >= n && pend == 0)) @(negedge clk);
    endtask

    task automatic soft_go(input bit na, input bit rr, input bit an, input bit s,
                           input bit f, input logic [2:0] d, input bit pe);
        @(posedge clk); #1;
        arm_model();
        no_auto = na; rst_req = rr; aneg = an; spd = s; fdx = f; dwell = d; poll_en = pe;
        if (!na) begin
            if (rr) wq.push_back(16'h8000);
            wq.push_back(an ? 16'h1000 : {2'b00, s, 4'b0, f, 8'h00});
        end
        soft_rst = 1'b1;
        @(posedge clk); #1;
        soft_rst = 1'b0;
    endtask

    initial begin
        int f0;
        time t0;
        rst_n = 0; soft_rst = 0; poll_en = 1; no_auto = 0; rst_req = 1;
        aneg = 1; fdx = 0; spd = 0; dwell = 3'd0; mdio_in = 1'b1;
        frames_seen = 0; reads_done = 0; exp_changes = 0; seen_changes = 0;
        prev_poll = 16'h0; mdc_prev = 0; pend = 0;
        repeat (5) @(negedge clk);
        // R10: reset state
        chk(mdc == 1'b0, "R10 mdc", mdc, 0);
        chk(mdio_oe == 1'b0, "R10 oe", mdio_oe, 0);
        chk(poll_data == 16'h0, "R10 poll_data", poll_data, 0);
        chk(poll_change == 1'b0, "R10 poll_change", poll_change, 0);
        // T1: reset frame, aneg on, continuous polling
        @(posedge clk); #1;
        arm_model();
        wq.push_back(16'h8000); wq.push_back(16'h1000);
        rst_n = 1;
        @(posedge mdc); t0 = $time;
        @(posedge mdc);
        chk(($time - t0) == 2 * HALF * CLK_PERIOD, "R9 mdc period", $time - t0, 2 * HALF * CLK_PERIOD);
        wait_reads(4);
        // R8: soft reset in the middle of a read frame
        while (!in_frame) @(negedge clk);
        repeat (100) @(negedge clk);
        // T2: forced 100M full duplex, dwell 128
        soft_go(0, 0, 0, 1, 1, 3'd1, 1);
        wait_reads(reads_done + 3);
        // T3: reset + forced 10M full duplex, reserved dwell code
        soft_go(0, 1, 0, 0, 1, 3'd6, 1);
        wait_reads(reads_done + 2);
        // T4: auto setup disabled, no polling -> silence (R5)
        soft_go(1, 1, 1, 1, 1, 3'd5, 0);
        f0 = frames_seen;
        repeat (400 * 2 * HALF) @(negedge clk);
        chk(frames_seen == f0, "R5 no frames", frames_seen, f0);
        chk(mdio_oe == 1'b0, "R5 oe idle", mdio_oe, 0);
        @(posedge clk); #1; poll_en = 1;
        wait_reads(reads_done + 2);
        chk(wq.size() == 0, "R3 setup frames consumed", wq.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule